// File: doc/BRIEF.md
# Extension Operand Value Generator

This block turns the decoded operand fields of one instruction into the final 64-bit immediate or address offset. It takes the extension-length code, the raw extension bits already assembled by the fetch path, and the short "quick" constants held inside the opcode. It returns the operand value, sign-extended to the width the instruction needs, and the number of 16-bit extension words the instruction used.

When the instruction carries no extension words, the block falls back to a quick constant. The 8-bit quick field wins over the 4-bit one. If neither is present the value is zero. Immediates are fitted to the operation width. Offsets are fitted to the machine pointer width, which is a parameter. A fitted result narrower than 64 bits is sign-extended across the whole bus, so every consumer sees one consistent form.

The datapath is combinational. A parameter can add one output register stage.

Top module: `ext_operand_gen`

## Requirements
- R1: `words_o` reports the extension length: `ext_spec` 00 gives 0, 01 gives 1, 10 gives 2 and 11 gives 4.
- R2: With `ext_spec` = 01, the source value is `ext_raw[15:0]` sign-extended from bit 15. Bits 63:16 of `ext_raw` have no effect.
- R3: With `ext_spec` = 10, the source value is `ext_raw[31:0]` sign-extended from bit 31. Bits 63:32 of `ext_raw` have no effect.
- R4: With `ext_spec` = 11, the source value is all 64 bits of `ext_raw`.
- R5: When `is_offset` = 0, the source value is cut to the operation width and sign-extended from its top bit. The width is selected by `op_size`: 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64.
- R6: When `is_offset` = 1, the source value is cut to `PTR_W` bits (32 or 64) and sign-extended from bit `PTR_W`-1. `op_size` has no effect.
- R7: With `ext_spec` = 00 and no quick field present, the source value is 0.
- R8: With `ext_spec` = 00, only `q4_present` set, the 4-bit code is read as two's complement, except that code 0000 stands for +8.
- R9: With `ext_spec` = 00 and `q8_present` set, the source value is `q8_code` as two's complement from -128 to +127. This holds whatever the 4-bit field holds.
- R10: When `ext_spec` is not 00, the quick fields and their present flags have no effect on the value.
- R11: With `REG_OUT` = 1, the outputs show the result for the inputs of the previous rising clock edge. While `rst_n` is low the outputs are 0. With `REG_OUT` = 0, the outputs follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| op_size | input | 2 | Integer operation size code |
| ext_spec | input | 2 | Extension length code |
| is_offset | input | 1 | 1: the value is an address offset; 0: it is an immediate |
| q4_present | input | 1 | The 4-bit quick field is free to supply the value |
| q4_code | input | 4 | 4-bit quick code |
| q8_present | input | 1 | The 8-bit quick field is free to supply the value |
| q8_code | input | 8 | 8-bit quick code |
| ext_raw | input | 64 | Assembled extension bits, right-aligned |
| value_o | output | 64 | Fitted operand value |
| words_o | output | 3 | Number of 16-bit extension words used |

## Verification
The bench builds two copies of the block.

The first uses a 32-bit pointer with the output register enabled. This covers offset truncation, where a 64-bit extension loses its upper half. It also checks the one-cycle latency and the cleared state during reset.

The second uses a 64-bit pointer with no register. Here an offset passes through at full width, and the result is compared in the same cycle as the stimulus.

Both copies sweep every combination of size code, length code, use flag and quick-present flags. Each combination runs against all sixteen 4-bit codes, the 8-bit extremes and raw patterns whose upper bits disagree with the sign of the selected part.

// File: rtl/ext_operand_pkg.sv
`timescale 1ns/1ps
package ext_operand_pkg;

  typedef enum logic [1:0] {
    EXT_NONE = 2'b00,
    EXT_H16  = 2'b01,
    EXT_W32  = 2'b10,
    EXT_D64  = 2'b11
  } ext_len_e;

  localparam int unsigned VAL_W   = 64;
  localparam int unsigned WORDS_W = 3;

  // number of 16-bit words carried by a length code
  function automatic logic [WORDS_W-1:0] words_for(input ext_len_e len);
    case (len)
      EXT_H16: return 3'd1;
      EXT_W32: return 3'd2;
      EXT_D64: return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // integer operation width in bits for a size code
  function automatic int unsigned op_bits(input logic [1:0] sz);
    return 32'd8 << sz;
  endfunction

  // keep the low 'bits' bits and replicate the top kept bit upward
  function automatic logic [VAL_W-1:0] sext_from(input logic [VAL_W-1:0] v,
                                                 input int unsigned bits);
    case (bits)
      8:       return {{56{v[7]}},  v[7:0]};
      16:      return {{48{v[15]}}, v[15:0]};
      32:      return {{32{v[31]}}, v[31:0]};
      default: return v;
    endcase
  endfunction

endpackage

// File: rtl/ext_raw_select.sv
`timescale 1ns/1ps
module ext_raw_select
  import ext_operand_pkg::*;
(
  input  logic [1:0]       ext_spec,
  input  logic [VAL_W-1:0] ext_raw,
  output logic [VAL_W-1:0] ext_val,
  output logic             ext_absent
);
  ext_len_e len;
  assign len = ext_len_e'(ext_spec);

  always_comb begin
    ext_absent = 1'b0;
    case (len)
      EXT_H16: ext_val = sext_from(ext_raw, 16);
      EXT_W32: ext_val = sext_from(ext_raw, 32);
      EXT_D64: ext_val = ext_raw;
      default: begin
        ext_val    = '0;
        ext_absent = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/ext_quick_decode.sv
`timescale 1ns/1ps
module ext_quick_decode
  import ext_operand_pkg::*;
(
  input  logic             q4_present,
  input  logic [3:0]       q4_code,
  input  logic             q8_present,
  input  logic [7:0]       q8_code,
  output logic [VAL_W-1:0] quick_val
);
  logic [VAL_W-1:0] q4_val;
  logic [VAL_W-1:0] q8_val;

  // code 0000 stands for +8, the rest is plain two's complement
  assign q4_val = (q4_code == 4'b0000) ? 64'd8 : {{60{q4_code[3]}}, q4_code};
  assign q8_val = {{56{q8_code[7]}}, q8_code};

  always_comb begin
    if (q8_present)      quick_val = q8_val;
    else if (q4_present) quick_val = q4_val;
    else                 quick_val = '0;
  end
endmodule

// File: rtl/ext_width_fit.sv
`timescale 1ns/1ps
module ext_width_fit
  import ext_operand_pkg::*;
#(
  parameter int unsigned PTR_W = 64
)(
  input  logic [VAL_W-1:0] src_val,
  input  logic             is_offset,
  input  logic [1:0]       op_size,
  output logic [VAL_W-1:0] fit_val
);
  logic [VAL_W-1:0] imm_fit;
  logic [VAL_W-1:0] off_fit;

  assign imm_fit = sext_from(src_val, op_bits(op_size));

  generate
    if (PTR_W == 32) begin : g_ptr32
      assign off_fit = {{32{src_val[31]}}, src_val[31:0]};
    end else begin : g_ptr64
      assign off_fit = src_val;
    end
  endgenerate

  assign fit_val = is_offset ? off_fit : imm_fit;
endmodule

// File: rtl/ext_operand_gen.sv
`timescale 1ns/1ps
module ext_operand_gen
  import ext_operand_pkg::*;
#(
  parameter int unsigned PTR_W   = 64,
  parameter bit          REG_OUT = 1'b1
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  op_size,
  input  logic [1:0]  ext_spec,
  input  logic        is_offset,
  input  logic        q4_present,
  input  logic [3:0]  q4_code,
  input  logic        q8_present,
  input  logic [7:0]  q8_code,
  input  logic [63:0] ext_raw,
  output logic [63:0] value_o,
  output logic [2:0]  words_o
);
  // named internal events, visible to the bound checker
  logic [VAL_W-1:0]   ext_val;
  logic               ext_absent;
  logic [VAL_W-1:0]   quick_val;
  logic [VAL_W-1:0]   sel_value;
  logic [VAL_W-1:0]   fit_value;
  logic [WORDS_W-1:0] words_comb;

  ext_raw_select u_raw (
    .ext_spec   (ext_spec),
    .ext_raw    (ext_raw),
    .ext_val    (ext_val),
    .ext_absent (ext_absent)
  );

  ext_quick_decode u_quick (
    .q4_present (q4_present),
    .q4_code    (q4_code),
    .q8_present (q8_present),
    .q8_code    (q8_code),
    .quick_val  (quick_val)
  );

  assign sel_value  = ext_absent ? quick_val : ext_val;
  assign words_comb = words_for(ext_len_e'(ext_spec));

  ext_width_fit #(.PTR_W(PTR_W)) u_fit (
    .src_val   (sel_value),
    .is_offset (is_offset),
    .op_size   (op_size),
    .fit_val   (fit_value)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          value_o <= '0;
          words_o <= '0;
        end else begin
          value_o <= fit_value;
          words_o <= words_comb;
        end
      end
    end else begin : g_comb
      assign value_o = fit_value;
      assign words_o = words_comb;
    end
  endgenerate
endmodule

// File: rtl/ext_operand_gen_chk.sv
`timescale 1ns/1ps
module ext_operand_gen_chk #(
  parameter int unsigned PTR_W   = 64,
  parameter bit          REG_OUT = 1'b1
)(
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  op_size,
  input logic [1:0]  ext_spec,
  input logic        is_offset,
  input logic        q4_present,
  input logic [3:0]  q4_code,
  input logic        q8_present,
  input logic [63:0] fit_value,
  input logic [2:0]  words_comb,
  input logic [63:0] value_o,
  input logic [2:0]  words_o
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_words_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(words_comb) && ((ext_spec == 2'b00) == (words_comb == 3'd0)));

  assert_imm8_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_offset && op_size == 2'b00) |-> (fit_value[63:8] == {56{fit_value[7]}}));

  assert_imm16_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_offset && op_size == 2'b01) |-> (fit_value[63:16] == {48{fit_value[15]}}));

  generate
    if (PTR_W == 32) begin : g_off32
      assert_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        is_offset |-> (fit_value[63:32] == {32{fit_value[31]}}));
    end
  endgenerate

  assert_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_spec == 2'b00 && !q4_present && !q8_present) |-> (fit_value == 64'd0));

  assert_q4_eight_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_spec == 2'b00 && q4_present && !q8_present && q4_code == 4'b0000
     && (is_offset || op_size != 2'b00 || 1'b1)) |-> (fit_value == 64'd8));

  generate
    if (REG_OUT) begin : g_pipe
      assert_pipe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (value_o == $past(fit_value) && words_o == $past(words_comb)));
    end else begin : g_flow
      assert_flow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (value_o == fit_value) && (words_o == words_comb));
    end
  endgenerate
endmodule

bind ext_operand_gen ext_operand_gen_chk #(.PTR_W(PTR_W), .REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_size    (op_size),
  .ext_spec   (ext_spec),
  .is_offset  (is_offset),
  .q4_present (q4_present),
  .q4_code    (q4_code),
  .q8_present (q8_present),
  .fit_value  (fit_value),
  .words_comb (words_comb),
  .value_o    (value_o),
  .words_o    (words_o)
);

// File: tb/ext_operand_gen_bench.sv
`timescale 1ns/1ps
module ext_operand_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_size = '0;
  logic [1:0]  ext_spec = '0;
  logic        is_offset = 1'b0;
  logic        q4_present = 1'b0;
  logic [3:0]  q4_code = '0;
  logic        q8_present = 1'b0;
  logic [7:0]  q8_code = '0;
  logic [63:0] ext_raw = '0;
  logic [63:0] val_a, val_b;
  logic [2:0]  wrd_a, wrd_b;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  // 32-bit pointer, registered output
  ext_operand_gen #(.PTR_W(32), .REG_OUT(1'b1)) u_ext_operand_gen (
    .clk(clk), .rst_n(rst_n), .op_size(op_size), .ext_spec(ext_spec),
    .is_offset(is_offset), .q4_present(q4_present), .q4_code(q4_code),
    .q8_present(q8_present), .q8_code(q8_code), .ext_raw(ext_raw),
    .value_o(val_a), .words_o(wrd_a));

  // 64-bit pointer, combinational output
  ext_operand_gen #(.PTR_W(64), .REG_OUT(1'b0)) u_ext_operand_gen_w64 (
    .clk(clk), .rst_n(rst_n), .op_size(op_size), .ext_spec(ext_spec),
    .is_offset(is_offset), .q4_present(q4_present), .q4_code(q4_code),
    .q8_present(q8_present), .q8_code(q8_code), .ext_raw(ext_raw),
    .value_o(val_b), .words_o(wrd_b));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h (sz=%0d spec=%0d off=%0b q4p=%0b q4=%h q8p=%0b q8=%h raw=%h)",
               tag, act, exp, op_size, ext_spec, is_offset, q4_present, q4_code,
               q8_present, q8_code, ext_raw);
    end
  endtask

  function automatic logic [63:0] model(input int pw);
    longint b;
    int w;
    case (ext_spec)
      2'd0: begin
        if (q8_present)      b = longint'($signed(q8_code));
        else if (q4_present) b = (q4_code == 4'd0) ? 64'sd8 : longint'($signed(q4_code));
        else                 b = 0;
      end
      2'd1: b = longint'($signed(ext_raw[15:0]));
      2'd2: b = longint'($signed(ext_raw[31:0]));
      default: b = longint'(ext_raw);
    endcase
    w = is_offset ? pw : (8 << op_size);
    if (w < 64) b = (b <<< (64 - w)) >>> (64 - w);
    return b;
  endfunction

  function automatic logic [2:0] words_model();
    return (ext_spec == 2'd0) ? 3'd0 : (3'd1 << (ext_spec - 2'd1));
  endfunction

  function automatic string value_tag();
    if (ext_spec == 2'd0) return q8_present ? "R9" : (q4_present ? "R8" : "R7");
    if (q4_present || q8_present) return "R10";
    if (is_offset) return "R6";
    case (ext_spec)
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  initial begin
    #800000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] raw_pat [3];
    logic [7:0]  q8_pat [4];
    logic [63:0] prev_val;
    logic [2:0]  prev_wrd;
    string       prev_tag;
    bit          have_prev;
    raw_pat[0] = 64'hFEDC_BA98_7654_3210;
    raw_pat[1] = 64'h0123_4567_89AB_CDEF;
    raw_pat[2] = 64'h7FFF_8000_FFFF_7F85;
    q8_pat[0] = 8'h00; q8_pat[1] = 8'h7F; q8_pat[2] = 8'h80; q8_pat[3] = 8'hC3;
    have_prev = 1'b0;
    prev_val = '0; prev_wrd = '0; prev_tag = "";

    // reset: drive busy inputs, registered outputs must stay clear (R11)
    ext_spec = 2'd3; ext_raw = '1; is_offset = 1'b1;
    repeat (3) @(negedge clk);
    check("R11", val_a, 64'd0);
    check("R11", {61'd0, wrd_a}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int sz = 0; sz < 4; sz++)
      for (int sp = 0; sp < 4; sp++)
        for (int off = 0; off < 2; off++)
          for (int qf = 0; qf < 4; qf++)
            for (int rp = 0; rp < 3; rp++)
              for (int k8 = 0; k8 < 4; k8++)
                for (int k4 = 0; k4 < 16; k4++) begin
                  @(negedge clk);
                  if (have_prev) begin
                    check({prev_tag, "/R11"}, val_a, prev_val);
                    check("R1/R11", {61'd0, wrd_a}, {61'd0, prev_wrd});
                  end
                  op_size    = 2'(sz);
                  ext_spec   = 2'(sp);
                  is_offset  = off[0];
                  q4_present = qf[0];
                  q8_present = qf[1];
                  ext_raw    = raw_pat[rp];
                  q8_code    = q8_pat[k8];
                  q4_code    = 4'(k4);
                  #1;
                  check(value_tag(), val_b, model(64));
                  check(is_offset ? "R6" : "R5", val_b, model(64));
                  check("R1", {61'd0, wrd_b}, {61'd0, words_model()});
                  prev_val  = model(32);
                  prev_wrd  = words_model();
                  prev_tag  = is_offset ? "R6" : value_tag();
                  have_prev = 1'b1;
                end
    @(negedge clk);
    check({prev_tag, "/R11"}, val_a, prev_val);

    // reset again while running: registered output clears (R11)
    rst_n = 1'b0;
    #1;
    check("R11", val_a, 64'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule